// File: doc/BRIEF.md
# Cache Slice Event Counter Unit

This block watches a shared cache slice through a set of single-cycle event strobes and keeps eight 48-bit event counters that software programs and reads over a simple 64-bit register bus. Each counter picks one event with an 8-bit code. It counts only while its own enable and a global run bit are both set.

When a counter rolls over from all ones to zero, it raises a per-counter overflow flag. Software clears a flag by writing a one to the matching bit of a clear register. The interrupt line is the registered OR of every flag that is not masked. Software normally preloads a counter with a period, lets it run, and on an interrupt reads the counter, reloads it and clears the flag.

The bus takes one request per cycle and answers one cycle later. Unmapped addresses read as zero and ignore writes.

Top module: `cache_perfmon`

## Requirements
- R1: After reset all counters are 0, the run bit is 0, all counter enables are 0, every code byte in the select registers is 0xFF, all mask bits are 1, all flags are 0 and `irq_o` is 0.
- R2: A request (`req_i`=1) gives `ready_o`=1 exactly one cycle later, and only then. For a read, `rdata_o` holds the register value in that same cycle. An unmapped address reads 0 and a write to it changes nothing.
- R3: Counter i sits at address 0x1E00 + 8·i. Its bits 63:48 always read 0, and write data in those bits is dropped.
- R4: The run bit is bit 17 of the register at 0x0408. All other bits of that register read 0. While the run bit is 0, no counter changes except through a bus write.
- R5: Bit i of the register at 0x1C00 enables counter i. A counter advances only when its enable bit and the run bit are both 1.
- R6: The select register at 0x1D00 holds the codes for counters 0–3 and the one at 0x1D04 holds the codes for counters 4–7. Counter i uses bits [8·(i mod 4)+7 : 8·(i mod 4)]. Both registers read back what was written.
- R7: Strobe bit k of `evt_i` stands for one code. Bits 0–4 are codes 0x00–0x04, bits 5–8 are 0x20–0x23, bit 9 is 0x29, and bits 10–12 are 0x40–0x42. An enabled counter adds 1 in each cycle its selected strobe is high. A counter whose code is 0xFF or any other code outside this list never counts.
- R8: A counter at 0xFFFF_FFFF_FFFF that counts wraps to 0 and sets its flag at the same clock edge. It keeps counting after the wrap.
- R9: The flags read at 0x0808, one bit per counter, and writes to that address are ignored. Writing 1 to bit i of the register at 0x080C clears flag i. A 0 bit there has no effect.
- R10: The mask register at 0x0800 has one bit per counter, where 0 enables and 1 masks. `irq_o` rises one cycle after any flag is set with its mask bit 0. It stays high until no such flag remains, then falls one cycle later.
- R11: When a bus write to a counter and an event for that counter land in the same cycle, the written value is kept.
- R12: When a clear of flag i and a new overflow of counter i land in the same cycle, flag i ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address of the register |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid with ready |
| ready_o | output | 1 | Access done, one cycle after request |
| evt_i | input | 13 | Event strobes, one per supported code |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
A corrupted counter stays hidden until software reads that counter's slot, or until the counter wraps and sets its flag early or late. The bench therefore reads every slot after each counting phase and compares each one against a count kept in the bench. A wrong flag or mask bit shows on `irq_o` within one cycle, and on the status read at the next access. The edge cases are write-versus-event and clear-versus-overflow in the same cycle. These are driven in one chosen cycle and then read back, because a wrong priority leaves a value off by exactly one, or a flag that is missing.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    parameter int NUM_CTR    = 8;
    parameter int CTR_W      = 48;
    parameter int BUS_W      = 64;
    parameter int ADDR_W     = 16;
    parameter int CODE_W     = 8;
    parameter int NUM_EVT    = 13;
    parameter int LANES      = 4;
    parameter int CFG_W      = 32;
    parameter int RUN_BIT    = 17;

    localparam int NUM_SEL   = NUM_CTR / LANES;
    localparam int CIDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int SIDX_W    = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
    localparam int SLOT_B    = 8;

    localparam logic [ADDR_W-1:0] RUN_ADDR  = 16'h0408;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 16'h0800;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 16'h0808;
    localparam logic [ADDR_W-1:0] CLR_ADDR  = 16'h080C;
    localparam logic [ADDR_W-1:0] CEN_ADDR  = 16'h1C00;
    localparam logic [ADDR_W-1:0] SEL_BASE  = 16'h1D00;
    localparam logic [ADDR_W-1:0] CTR_BASE  = 16'h1E00;

    localparam logic [CODE_W-1:0] CODE_IDLE = 8'hFF;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_RUN,
        RD_CEN,
        RD_SEL,
        RD_MASK,
        RD_FLAG,
        RD_CTR
    } rd_kind_t;

    typedef struct packed {
        logic               run;
        logic               cen;
        logic [NUM_SEL-1:0] sel;
        logic               mask;
        logic               clr;
        logic [NUM_CTR-1:0] ctr;
    } wr_sel_t;

    // Code carried by strobe bit k; the strobe order is fixed by the port.
    function automatic logic [CODE_W-1:0] strobe_code(input int k);
        if (k < 5)       return CODE_W'(k);
        else if (k < 9)  return CODE_W'(8'h20 + k - 5);
        else if (k == 9) return 8'h29;
        else             return CODE_W'(8'h40 + k - 10);
    endfunction

    // Strobes that feed a counter programmed with this code.
    function automatic logic [NUM_EVT-1:0] code_strobes(input logic [CODE_W-1:0] code);
        logic [NUM_EVT-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (strobe_code(k) == code) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pmu_decode.sv
module pmu_decode
    import pmu_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           wsel,
    output rd_kind_t          rkind,
    output logic [CIDX_W-1:0] ridx
);

    logic [ADDR_W-1:0] ctr_off;
    logic              in_ctr;
    wr_sel_t           hit;

    assign ctr_off = addr - CTR_BASE;
    assign in_ctr  = (addr >= CTR_BASE) &&
                     (ctr_off < ADDR_W'(SLOT_B * NUM_CTR)) &&
                     (ctr_off[2:0] == 3'b000);

    always_comb begin
        hit   = '0;
        rkind = RD_NONE;
        ridx  = '0;
        if (addr == RUN_ADDR) begin
            hit.run = 1'b1;
            rkind   = RD_RUN;
        end else if (addr == CEN_ADDR) begin
            hit.cen = 1'b1;
            rkind   = RD_CEN;
        end else if (addr == MASK_ADDR) begin
            hit.mask = 1'b1;
            rkind    = RD_MASK;
        end else if (addr == FLAG_ADDR) begin
            rkind = RD_FLAG;
        end else if (addr == CLR_ADDR) begin
            hit.clr = 1'b1;
        end else if (in_ctr) begin
            rkind = RD_CTR;
            ridx  = ctr_off[3 +: CIDX_W];
            hit.ctr[ctr_off[3 +: CIDX_W]] = 1'b1;
        end else begin
            for (int k = 0; k < NUM_SEL; k++) begin
                if (addr == SEL_BASE + ADDR_W'(4 * k)) begin
                    hit.sel[k] = 1'b1;
                    rkind      = RD_SEL;
                    ridx       = CIDX_W'(k);
                end
            end
        end
    end

    assign wsel = (req && we) ? hit : '0;

endmodule

// File: rtl/pmu_config.sv
module pmu_config
    import pmu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_sel_t                   wsel,
    input  logic [CFG_W-1:0]          wdata,
    output logic                      run_en,
    output logic [NUM_CTR-1:0]        cen,
    output logic [NUM_CTR-1:0]        mask,
    output logic [NUM_CTR*CODE_W-1:0] codes
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            cen    <= '0;
            mask   <= '1;
        end else begin
            if (wsel.run)  run_en <= wdata[RUN_BIT];
            if (wsel.cen)  cen    <= wdata[NUM_CTR-1:0];
            if (wsel.mask) mask   <= wdata[NUM_CTR-1:0];
        end
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_selreg
        always_ff @(posedge clk) begin
            if (rst) begin
                codes[k*LANES*CODE_W +: LANES*CODE_W] <= {LANES{CODE_IDLE}};
            end else if (wsel.sel[k]) begin
                codes[k*LANES*CODE_W +: LANES*CODE_W] <= wdata[LANES*CODE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr,
    input  logic [CTR_W-1:0]   wdata,
    output logic [CTR_W-1:0]   count,
    output logic               wrap
);

    logic inc;

    assign inc  = run && (|(evt & code_strobes(code)));
    assign wrap = inc && !wr && (&count);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (wr)   count <= wdata;
        else if (inc)  count <= count + CTR_W'(1);
    end

endmodule

// File: rtl/pmu_irq.sv
module pmu_irq
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] wrap,
    input  logic               clr_wr,
    input  logic [NUM_CTR-1:0] clr_bits,
    input  logic [NUM_CTR-1:0] mask,
    output logic [NUM_CTR-1:0] flags,
    output logic               irq
);

    logic [NUM_CTR-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= (flags & ~clr_eff) | wrap;
            irq   <= |(flags & ~mask);
        end
    end

endmodule

// File: rtl/cache_perfmon.sv
module cache_perfmon
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BUS_W-1:0]   wdata_i,
    output logic [BUS_W-1:0]   rdata_o,
    output logic               ready_o,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o
);

    wr_sel_t                   wsel;
    rd_kind_t                  rkind;
    logic [CIDX_W-1:0]         ridx;
    logic                      run_en;
    logic [NUM_CTR-1:0]        cen;
    logic [NUM_CTR-1:0]        mask;
    logic [NUM_CTR*CODE_W-1:0] codes;
    logic [NUM_CTR-1:0]        wrap;
    logic [NUM_CTR-1:0]        flags;
    logic [NUM_CTR*CTR_W-1:0]  ctr_flat;
    logic [NUM_CTR-1:0]        ctr_wr_vec;
    logic                      clr_wr_en;
    logic [BUS_W-1:0]          rd_val;
    logic [CTR_W-1:0]          ctr_sel;
    logic [LANES*CODE_W-1:0]   sel_word;
    logic                      unused_hi;

    assign unused_hi  = ^wdata_i[BUS_W-1:CTR_W];
    assign ctr_wr_vec = wsel.ctr;
    assign clr_wr_en  = wsel.clr;

    pmu_decode u_decode (
        .req   (req_i),
        .we    (we_i),
        .addr  (addr_i),
        .wsel  (wsel),
        .rkind (rkind),
        .ridx  (ridx)
    );

    pmu_config u_config (
        .clk    (clk),
        .rst    (rst),
        .wsel   (wsel),
        .wdata  (wdata_i[CFG_W-1:0]),
        .run_en (run_en),
        .cen    (cen),
        .mask   (mask),
        .codes  (codes)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pmu_counter u_counter (
            .clk   (clk),
            .rst   (rst),
            .run   (run_en && cen[i]),
            .code  (codes[i*CODE_W +: CODE_W]),
            .evt   (evt_i),
            .wr    (wsel.ctr[i]),
            .wdata (wdata_i[CTR_W-1:0]),
            .count (ctr_flat[i*CTR_W +: CTR_W]),
            .wrap  (wrap[i])
        );
    end

    pmu_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .clr_wr   (wsel.clr),
        .clr_bits (wdata_i[NUM_CTR-1:0]),
        .mask     (mask),
        .flags    (flags),
        .irq      (irq_o)
    );

    assign ctr_sel  = ctr_flat[ridx*CTR_W +: CTR_W];
    assign sel_word = codes[ridx[SIDX_W-1:0]*LANES*CODE_W +: LANES*CODE_W];

    always_comb begin
        case (rkind)
            RD_RUN:  rd_val = BUS_W'(run_en) << RUN_BIT;
            RD_CEN:  rd_val = BUS_W'(cen);
            RD_SEL:  rd_val = BUS_W'(sel_word);
            RD_MASK: rd_val = BUS_W'(mask);
            RD_FLAG: rd_val = BUS_W'(flags);
            RD_CTR:  rd_val = BUS_W'(ctr_sel);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_o <= 1'b0;
            rdata_o <= '0;
        end else begin
            ready_o <= req_i;
            rdata_o <= (req_i && !we_i) ? rd_val : '0;
        end
    end

endmodule

// File: rtl/cache_perfmon_chk.sv
module cache_perfmon_chk
    import pmu_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     req_i,
    input logic                     we_i,
    input logic [ADDR_W-1:0]        addr_i,
    input logic [BUS_W-1:0]         rdata_o,
    input logic                     ready_o,
    input logic                     irq_o,
    input logic                     run_en,
    input logic [NUM_CTR-1:0]       mask,
    input logic [NUM_CTR-1:0]       flags,
    input logic [NUM_CTR*CTR_W-1:0] ctr_flat,
    input logic [NUM_CTR-1:0]       ctr_wr_vec,
    input logic                     clr_wr_en,
    input logic [NUM_CTR-1:0]       clr_bits
);

    logic ctr_read;
    assign ctr_read = req_i && !we_i && (addr_i >= CTR_BASE) &&
                      (addr_i < CTR_BASE + ADDR_W'(SLOT_B * NUM_CTR));

    AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_i |=> ready_o); // R2
    AST_NO_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !ready_o); // R2
    AST_SLOT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctr_read |=> (rdata_o[BUS_W-1:CTR_W] == '0)); // R3
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~mask)) |=> irq_o); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |=> !irq_o); // R10

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_per_ctr
        AST_HALT_NO_RUN: assert property (@(posedge clk) disable iff (rst)
            (!run_en && !ctr_wr_vec[i]) |=> $stable(ctr_flat[i*CTR_W +: CTR_W])); // R4
        AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
            (&ctr_flat[i*CTR_W +: CTR_W]) && !ctr_wr_vec[i] && run_en
            ##1 (ctr_flat[i*CTR_W +: CTR_W] == '0) |-> flags[i]); // R8
        AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
            $fell(flags[i]) |-> $past(clr_wr_en && clr_bits[i])); // R9
    end

endmodule

bind cache_perfmon cache_perfmon_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .ready_o    (ready_o),
    .irq_o      (irq_o),
    .run_en     (run_en),
    .mask       (mask),
    .flags      (flags),
    .ctr_flat   (ctr_flat),
    .ctr_wr_vec (ctr_wr_vec),
    .clr_wr_en  (clr_wr_en),
    .clr_bits   (wdata_i[pmu_pkg::NUM_CTR-1:0])
);

// File: tb/cache_perfmon_tb.sv
`timescale 1ns/1ps
module cache_perfmon_tb;
    import pmu_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_i = 1'b0;
    logic               we_i = 1'b0;
    logic [ADDR_W-1:0]  addr_i = '0;
    logic [BUS_W-1:0]   wdata_i = '0;
    logic [BUS_W-1:0]   rdata_o;
    logic               ready_o;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic               irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [BUS_W-1:0] exp_q[$];
    string            tag_q[$];
    bit               rd_q[$];

    always #4 clk = ~clk;

    cache_perfmon u_dut (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .ready_o (ready_o),
        .evt_i   (evt_i),
        .irq_o   (irq_o)
    );

    function automatic logic [ADDR_W-1:0] slot(input int i);
        return CTR_BASE + ADDR_W'(8 * i);
    endfunction

    task automatic check(input string tag, input logic [BUS_W-1:0] act,
                         input logic [BUS_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one scoreboard item per ready pulse.
    always @(negedge clk) begin
        if (!rst && ready_o) begin
            if (rd_q.size() == 0) begin
                check("R2 unexpected ready", 64'd1, 64'd0);
            end else begin
                automatic bit               is_rd = rd_q.pop_front();
                automatic logic [BUS_W-1:0] e     = exp_q.pop_front();
                automatic string            t     = tag_q.pop_front();
                if (is_rd) check(t, rdata_o, e);
            end
        end
    end

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        rd_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("");
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] e,
                          input string t);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        rd_q.push_back(1'b1); exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    // Hold the given strobes high across n rising edges.
    task automatic pulse(input logic [NUM_EVT-1:0] m, input int n);
        @(negedge clk);
        evt_i = m;
        repeat (n) @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check("R1 irq", 64'(irq_o), 64'd0);
        bus_rd(RUN_ADDR, 64'd0, "R1 run");
        bus_rd(CEN_ADDR, 64'd0, "R1 enables");
        bus_rd(SEL_BASE, 64'hFFFF_FFFF, "R1 select0");
        bus_rd(SEL_BASE + 16'd4, 64'hFFFF_FFFF, "R1 select1");
        bus_rd(MASK_ADDR, 64'hFF, "R1 mask");
        bus_rd(FLAG_ADDR, 64'd0, "R1 flags");
        bus_rd(slot(5), 64'd0, "R1 counter5");

        // R2 unmapped access
        bus_wr(16'h0010, 64'hDEAD_BEEF);
        bus_rd(16'h0010, 64'd0, "R2 unmapped");

        // R3 slot upper bits dropped
        bus_wr(slot(3), 64'hABCD_0000_1234_5678);
        bus_rd(slot(3), 64'h0000_0000_1234_5678, "R3 slot upper");

        // R6 code placement
        bus_wr(SEL_BASE, 64'hFFFF_FFFF_FF29_0200);
        bus_wr(SEL_BASE + 16'd4, 64'h21104240);
        bus_rd(SEL_BASE, 64'hFF29_0200, "R6 select0");
        bus_rd(SEL_BASE + 16'd4, 64'h2110_4240, "R6 select1");
        bus_wr(CEN_ADDR, 64'hFF);

        // R4 run bit clear: nothing counts
        pulse('1, 5);
        bus_rd(slot(0), 64'd0, "R4 halted c0");
        bus_rd(slot(7), 64'd0, "R4 halted c7");
        bus_wr(RUN_ADDR, 64'hFFFF_FFFF);
        bus_rd(RUN_ADDR, 64'h0002_0000, "R4 run bit only");

        // R7 counting and code routing
        pulse('1, 1);
        pulse(13'h0001, 3);
        pulse(13'h0004, 4);
        pulse(13'h0200, 2);
        pulse(13'h0400, 1);
        pulse(13'h1000, 2);
        pulse(13'h0040, 3);
        pulse(13'h0008, 2);
        bus_rd(slot(0), 64'd4, "R7 c0");
        bus_rd(slot(1), 64'd5, "R7 c1");
        bus_rd(slot(2), 64'd3, "R7 c2");
        bus_rd(slot(3), 64'h1234_5678, "R7 idle code");
        bus_rd(slot(4), 64'd2, "R7 c4");
        bus_rd(slot(5), 64'd3, "R7 c5");
        bus_rd(slot(6), 64'd0, "R7 unlisted code");
        bus_rd(slot(7), 64'd4, "R7 c7");

        // R5 per-counter enable
        bus_wr(CEN_ADDR, 64'hFE);
        pulse(13'h0001, 2);
        bus_rd(slot(0), 64'd4, "R5 disabled c0");
        bus_rd(CEN_ADDR, 64'hFE, "R5 enables");

        // R8 wrap and R10 interrupt
        bus_wr(slot(1), 64'h0000_FFFF_FFFF_FFFE);
        bus_wr(MASK_ADDR, 64'hFD);
        pulse(13'h0004, 3);
        check("R10 irq raised", 64'(irq_o), 64'd1);
        bus_rd(slot(1), 64'd1, "R8 keeps counting");
        bus_rd(FLAG_ADDR, 64'h02, "R8 flag set");
        bus_wr(MASK_ADDR, 64'hFF);
        @(negedge clk);
        check("R10 masked", 64'(irq_o), 64'd0);
        bus_wr(MASK_ADDR, 64'hFD);
        @(negedge clk);
        check("R10 unmasked", 64'(irq_o), 64'd1);

        // R9 clear semantics
        bus_wr(CLR_ADDR, 64'd0);
        bus_wr(FLAG_ADDR, 64'd0);
        bus_rd(FLAG_ADDR, 64'h02, "R9 zero writes ignored");
        bus_wr(CLR_ADDR, 64'h02);
        bus_rd(FLAG_ADDR, 64'd0, "R9 cleared");
        check("R10 irq low", 64'(irq_o), 64'd0);

        // R11 write beats event
        @(negedge clk);
        evt_i = 13'h0040;
        req_i = 1'b1; we_i = 1'b1; addr_i = slot(7); wdata_i = 64'd100;
        rd_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("");
        @(negedge clk);
        evt_i = '0; req_i = 1'b0; we_i = 1'b0;
        bus_rd(slot(7), 64'd100, "R11 write wins");

        // R12 overflow beats clear (counter 4, masked)
        bus_wr(slot(4), 64'h0000_FFFF_FFFF_FFFF);
        pulse(13'h0400, 1);
        bus_rd(FLAG_ADDR, 64'h10, "R8 c4 flag");
        check("R10 masked flag", 64'(irq_o), 64'd0);
        bus_wr(CLR_ADDR, 64'h10);
        bus_wr(slot(4), 64'h0000_FFFF_FFFF_FFFF);
        @(negedge clk);
        evt_i = 13'h0400;
        req_i = 1'b1; we_i = 1'b1; addr_i = CLR_ADDR; wdata_i = 64'h10;
        rd_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("");
        @(negedge clk);
        evt_i = '0; req_i = 1'b0; we_i = 1'b0;
        bus_rd(FLAG_ADDR, 64'h10, "R12 overflow kept");
        bus_rd(slot(4), 64'd0, "R8 c4 wrapped");
        bus_wr(CLR_ADDR, 64'h10);
        bus_rd(FLAG_ADDR, 64'd0, "R9 final clear");

        repeat (3) @(negedge clk);
        if (rd_q.size() != 0) check("R2 pending items", 64'(rd_q.size()), 64'd0);
        finish_run();
    end

endmodule